// File: doc/BRIEF.md
# Interrupt, Return Stack and Halt Sequencer

This block is the control sequencer next to the decoder of a small 4-bit processor core. The decoder marks the last clock of every instruction with a boundary strobe. Along with it come the strobes of the completing instruction: call, return, interrupt return, interrupt re-enable and bank select. At each such boundary the sequencer updates a circular return stack of seven 12-bit addresses. It decides whether to take a pending interrupt and tracks whether the core is running, halted or single-stepping. When the program counter must be redirected, it hands the core a new value for one cycle.

A working register file is part of the block. It has sixteen 4-bit registers, and an alternate set of eight registers can be laid over the low half of them. A handler switches that set in with one instruction, so the interrupted code's values stay untouched underneath. A halt request stops instruction issue at the next boundary while the boundary strobe keeps running, so an interrupt can still wake the core.

Top module: `irq_stack_halt_seq`

## Requirements
- R1: After reset, `pc_load`, `irq_ack`, `stop_ack`, `stk_ovf` and `bank_act` are 0, the stack is empty, interrupts are enabled and all registers read 0.
- R2: Strobes, interrupt requests, halt requests and bank commands have no effect on any clock edge where `cyc_stb` is 0.
- R3: At a boundary, `call_stb` pushes `pc_in`. `ret_stb` pops the newest entry, and in the next cycle `pc_load` is 1 and `pc_out` holds the popped value. Entries come back last-in first-out.
- R4: The stack holds seven entries. A push onto a full stack overwrites the oldest entry and sets `stk_ovf`, which stays 1 until reset. Seven pops after eight pushes return the 8th down to the 2nd value.
- R5: At a boundary with `irq_req` 1, interrupts enabled and no call or return strobe, the interrupt is taken. `pc_in` is pushed, and in the next cycle `irq_ack` is 1 for exactly one cycle, with `pc_load` 1 and `pc_out` = 12'h003.
- R6: A taken interrupt disables further acceptance. `iret_stb` (a pop, as in R3) or `irq_on_cmd` at a later boundary re-enables it, effective from the following boundary.
- R7: An interrupt pending at a boundary whose instruction issues a call, return or interrupt-return strobe is deferred to the next boundary.
- R8: `bank_cmd` at a boundary sets `bank_act` to `bank_val`. While `bank_act` is 1, addresses 0 to 7 read and write the alternate set, and addresses 8 to 15 stay shared. Switching back exposes the unchanged original values.
- R9: `stop_req` at a boundary while running sets `stop_ack` in the next cycle, and `stop_ack` holds while `stop_req` stays 1. While halted, call, return, re-enable and bank strobes are ignored.
- R10: With `step_mode` 0, a boundary where `stop_req` is 0 while halted returns the core to running and clears `stop_ack`.
- R11: With `step_mode` 1, a boundary where `stop_req` is 0 while halted releases exactly one instruction. At the next boundary `stop_ack` is 1 again, whatever the level of `stop_req`.
- R12: An interrupt taken while halted or stepping (R5) leaves the core running with `stop_ack` 0.
- R13: When an interrupt and `stop_req` arrive at the same running boundary, the interrupt is taken and the halt happens at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Last clock of an instruction (boundary) |
| call_stb | input | 1 | Completing instruction is a call |
| ret_stb | input | 1 | Completing instruction is a return |
| iret_stb | input | 1 | Completing instruction is an interrupt return |
| irq_on_cmd | input | 1 | Completing instruction re-enables interrupts |
| bank_cmd | input | 1 | Completing instruction selects a register bank |
| bank_val | input | 1 | Bank to select: 1 = alternate set |
| pc_in | input | 12 | Return address to push |
| irq_req | input | 1 | Interrupt request level |
| stop_req | input | 1 | Halt request level |
| step_mode | input | 1 | Single-step when released from halt |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 12 | Popped address or interrupt vector |
| irq_ack | output | 1 | One-cycle interrupt acceptance pulse |
| stop_ack | output | 1 | Core is halted |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| bank_act | output | 1 | Alternate register set is active |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 4 | Register write address |
| rf_wdata | input | 4 | Register write data |
| rf_raddr | input | 4 | Register read address |
| rf_rdata | output | 4 | Register read data |

## Verification
The stack is driven with short call/return nests, which separate LIFO order from queue order. A run of nine pushes and seven pops shows whether the oldest or the newest entry is lost on overflow. The interrupt is held high across several boundaries, so a missing self-disable appears as a second acknowledge. It is also raised alongside stack strobes and halt requests, which exposes the wrong priority at a shared boundary. Halt is released both with and without stepping, and with `stop_req` left low, to tell a one-instruction step from a plain resume. A long random mix of all strobes is compared every cycle against a queue-based model.

// File: rtl/irq_stack_halt_seq.sv
module irq_stack_halt_seq #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 7,
  parameter logic [PC_W-1:0] VEC = 'h003,
  parameter int DW    = 4,
  parameter int NREG  = 16,
  parameter int NALT  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_stb,
  input  logic                    call_stb,
  input  logic                    ret_stb,
  input  logic                    iret_stb,
  input  logic                    irq_on_cmd,
  input  logic                    bank_cmd,
  input  logic                    bank_val,
  input  logic [PC_W-1:0]         pc_in,
  input  logic                    irq_req,
  input  logic                    stop_req,
  input  logic                    step_mode,
  output logic                    pc_load,
  output logic [PC_W-1:0]         pc_out,
  output logic                    irq_ack,
  output logic                    stop_ack,
  output logic                    stk_ovf,
  output logic                    bank_act,
  input  logic                    rf_we,
  input  logic [$clog2(NREG)-1:0] rf_waddr,
  input  logic [DW-1:0]           rf_wdata,
  input  logic [$clog2(NREG)-1:0] rf_raddr,
  output logic [DW-1:0]           rf_rdata
);
  localparam int AW = $clog2(NREG);
  localparam int LW = $clog2(NALT);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] ALT_TOP = AW'(NALT);
  localparam logic [PW-1:0] PTR_TOP = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL    = CW'(DEPTH);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_STOP = 2'd1, S_STEP = 2'd2} hstate_t;

  hstate_t          st;
  logic [PC_W-1:0]  stk [DEPTH];
  logic [PW-1:0]    ptr;
  logic [CW-1:0]    fill;
  logic             irq_en;
  logic [DW-1:0]    b0 [NREG];
  logic [DW-1:0]    b1 [NALT];

  logic live, busy, take, push, pop;
  logic [PW-1:0] ptr_up, ptr_dn;

  assign live   = (st != S_STOP);
  assign busy   = live & (call_stb | ret_stb | iret_stb);
  assign take   = cyc_stb & irq_req & irq_en & ~busy;
  assign push   = take | (cyc_stb & live & call_stb);
  assign pop    = cyc_stb & live & ~call_stb & (ret_stb | iret_stb);
  assign ptr_up = (ptr == PTR_TOP) ? '0 : ptr + 1'b1;
  assign ptr_dn = (ptr == '0) ? PTR_TOP : ptr - 1'b1;
  assign stop_ack = (st == S_STOP);

  always_ff @(posedge clk) begin
    if (push) stk[ptr] <= pc_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      fill    <= '0;
      stk_ovf <= 1'b0;
    end else if (push) begin
      ptr <= ptr_up;
      if (fill == FULL) stk_ovf <= 1'b1;
      else              fill    <= fill + 1'b1;
    end else if (pop) begin
      ptr <= ptr_dn;
      if (fill != '0) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load <= 1'b0;
      irq_ack <= 1'b0;
      pc_out  <= '0;
    end else begin
      pc_load <= take | pop;
      irq_ack <= take;
      if (take)     pc_out <= VEC;
      else if (pop) pc_out <= stk[ptr_dn];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                         irq_en <= 1'b1;
    else if (take)                                      irq_en <= 1'b0;
    else if (cyc_stb && live && (iret_stb || irq_on_cmd)) irq_en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          bank_act <= 1'b0;
    else if (cyc_stb && live && bank_cmd) bank_act <= bank_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_RUN;
    else if (cyc_stb) begin
      if (take) st <= S_RUN;
      else begin
        case (st)
          S_RUN:   if (stop_req) st <= S_STOP;
          S_STOP:  if (!stop_req) st <= step_mode ? S_STEP : S_RUN;
          default: st <= S_STOP;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) b0[i] <= '0;
      for (int i = 0; i < NALT; i++) b1[i] <= '0;
    end else if (rf_we) begin
      if (bank_act && rf_waddr < ALT_TOP) b1[rf_waddr[LW-1:0]] <= rf_wdata;
      else                                b0[rf_waddr]         <= rf_wdata;
    end
  end

  assign rf_rdata = (bank_act && rf_raddr < ALT_TOP) ? b1[rf_raddr[LW-1:0]] : b0[rf_raddr];

endmodule

// File: rtl/irq_stack_halt_seq_chk.sv
module irq_stack_halt_seq_chk #(
  parameter int PC_W = 12,
  parameter logic [PC_W-1:0] VEC = 'h003
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_stb,
  input logic            irq_req,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_out,
  input logic            irq_ack,
  input logic            stop_ack,
  input logic            stk_ovf,
  input logic            bank_act
);
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |=> !irq_ack); // R5
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> (pc_load && pc_out == VEC)); // R5
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) !cyc_stb |=> (!pc_load && !irq_ack)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) stk_ovf |=> stk_ovf); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cyc_stb |=> $stable(stop_ack)); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cyc_stb |=> $stable(bank_act)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (stop_ack && cyc_stb && !irq_req) |=> !pc_load); // R9
endmodule

bind irq_stack_halt_seq irq_stack_halt_seq_chk #(.PC_W(PC_W), .VEC(VEC)) chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_req(irq_req),
  .pc_load(pc_load), .pc_out(pc_out), .irq_ack(irq_ack), .stop_ack(stop_ack),
  .stk_ovf(stk_ovf), .bank_act(bank_act)
);

// File: tb/irq_stack_halt_seq_test.sv
`timescale 1ns/1ps
module irq_stack_halt_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cyc_stb, call_stb, ret_stb, iret_stb, irq_on_cmd, bank_cmd, bank_val;
  logic [11:0] pc_in;
  logic irq_req, stop_req, step_mode, rf_we;
  logic [3:0] rf_waddr, rf_wdata, rf_raddr;
  logic pc_load, irq_ack, stop_ack, stk_ovf, bank_act;
  logic [11:0] pc_out;
  logic [3:0] rf_rdata;

  irq_stack_halt_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .call_stb(call_stb), .ret_stb(ret_stb),
    .iret_stb(iret_stb), .irq_on_cmd(irq_on_cmd), .bank_cmd(bank_cmd), .bank_val(bank_val),
    .pc_in(pc_in), .irq_req(irq_req), .stop_req(stop_req), .step_mode(step_mode),
    .pc_load(pc_load), .pc_out(pc_out), .irq_ack(irq_ack), .stop_ack(stop_ack),
    .stk_ovf(stk_ovf), .bank_act(bank_act), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  int mq[$];
  bit m_load, m_ack, m_ovf, m_bank, m_en;
  int m_pc, m_st;
  int mb0[16];
  int mb1[8];
  int vectors = 0, errors = 0;
  string phase = "R1";
  bit finished = 0;

  task automatic m_push(input int v);
    mq.push_back(v);
    if (mq.size() > 7) begin
      void'(mq.pop_front());
      m_ovf = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_load = 0; m_ack = 0; m_ovf = 0; m_bank = 0; m_en = 1; m_pc = 0; m_st = 0;
      foreach (mb0[i]) mb0[i] = 0;
      foreach (mb1[i]) mb1[i] = 0;
    end else begin
      bit live, busy, take;
      live = (m_st != 1);
      busy = live && (call_stb || ret_stb || iret_stb);
      take = cyc_stb && irq_req && m_en && !busy;
      if (rf_we) begin
        if (m_bank && rf_waddr < 8) mb1[rf_waddr] = rf_wdata;
        else mb0[rf_waddr] = rf_wdata;
      end
      m_load = 0;
      m_ack = take;
      if (take) begin
        m_push(pc_in); m_pc = 3; m_load = 1; m_en = 0;
      end else if (cyc_stb && live) begin
        if (call_stb) m_push(pc_in);
        else if (ret_stb || iret_stb) begin m_pc = mq.pop_back(); m_load = 1; end
        if (iret_stb || irq_on_cmd) m_en = 1;
      end
      if (cyc_stb && live && bank_cmd) m_bank = bank_val;
      if (cyc_stb) begin
        if (take) m_st = 0;
        else case (m_st)
          0: if (stop_req) m_st = 1;
          1: if (!stop_req) m_st = step_mode ? 2 : 0;
          default: m_st = 1;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic cmp();
    int er;
    er = (m_bank && rf_raddr < 8) ? mb1[rf_raddr] : mb0[rf_raddr];
    chk("R3 pc_load", int'(pc_load), int'(m_load));
    if (m_load) chk("R3 pc_out", int'(pc_out), m_pc);
    chk("R5 irq_ack", int'(irq_ack), int'(m_ack));
    chk("R9 stop_ack", int'(stop_ack), int'(m_st == 1));
    chk("R4 stk_ovf", int'(stk_ovf), int'(m_ovf));
    chk("R8 bank_act", int'(bank_act), int'(m_bank));
    chk("R8 rf_rdata", int'(rf_rdata), er);
  endtask

  task automatic cy(input bit b);
    cyc_stb = b;
    @(posedge clk);
    @(negedge clk);
    cmp();
    cyc_stb = 0; call_stb = 0; ret_stb = 0; iret_stb = 0;
    irq_on_cmd = 0; bank_cmd = 0; rf_we = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog [%s] actual=running expected=done", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cyc_stb = 0; call_stb = 0; ret_stb = 0; iret_stb = 0; irq_on_cmd = 0;
    bank_cmd = 0; bank_val = 0; pc_in = 0; irq_req = 0; stop_req = 0; step_mode = 0;
    rf_we = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 pc_load", int'(pc_load), 0);
    chk("R1 irq_ack", int'(irq_ack), 0);
    chk("R1 stop_ack", int'(stop_ack), 0);
    chk("R1 stk_ovf", int'(stk_ovf), 0);
    chk("R1 bank_act", int'(bank_act), 0);
    chk("R1 rf_rdata", int'(rf_rdata), 0);

    // R2: nothing acts without the boundary strobe
    phase = "R2";
    call_stb = 1; pc_in = 12'h0AA; irq_req = 1; cy(0);
    irq_req = 1; cy(0);
    chk("R2 pc_load", int'(pc_load), 0);
    irq_req = 0; stop_req = 1; cy(0);
    chk("R2 stop_ack", int'(stop_ack), 0);
    stop_req = 0; bank_cmd = 1; bank_val = 1; cy(0);
    chk("R2 bank_act", int'(bank_act), 0);

    // R3: LIFO order
    phase = "R3";
    for (int i = 1; i <= 3; i++) begin pc_in = 12'(i * 12'h111); call_stb = 1; cy(1); cy(0); end
    for (int i = 3; i >= 1; i--) begin
      ret_stb = 1; cy(1);
      chk("R3 pop", int'(pc_out), i * 'h111);
    end

    // R4: overflow overwrites oldest
    phase = "R4";
    for (int i = 1; i <= 9; i++) begin
      pc_in = 12'(i * 16 + 5); call_stb = 1; cy(1);
      if (i == 7) chk("R4 no ovf yet", int'(stk_ovf), 0);
      if (i == 8) chk("R4 ovf set", int'(stk_ovf), 1);
    end
    for (int i = 9; i >= 3; i--) begin
      ret_stb = 1; cy(1);
      chk("R4 pop", int'(pc_out), i * 16 + 5);
    end

    // R5 / R6: acceptance, self-disable, re-enable
    phase = "R5";
    irq_req = 1; pc_in = 12'h400; cy(1);
    chk("R5 ack", int'(irq_ack), 1);
    chk("R5 vector", int'(pc_out), 3);
    phase = "R6";
    cy(0); cy(1);
    chk("R6 blocked", int'(irq_ack), 0);
    irq_on_cmd = 1; cy(1);
    chk("R6 no ack on enable edge", int'(irq_ack), 0);
    pc_in = 12'h401; cy(1);
    chk("R6 forced re-enable", int'(irq_ack), 1);
    irq_req = 0;
    iret_stb = 1; cy(1);
    chk("R6 iret pop", int'(pc_out), 'h401);
    iret_stb = 1; cy(1);
    chk("R6 iret pop", int'(pc_out), 'h400);
    irq_req = 1; pc_in = 12'h420; cy(1);
    chk("R6 enabled by iret", int'(irq_ack), 1);
    irq_req = 0; iret_stb = 1; cy(1);

    // R7: deferral behind a stack strobe
    phase = "R7";
    irq_req = 1; call_stb = 1; pc_in = 12'h700; cy(1);
    chk("R7 deferred", int'(irq_ack), 0);
    pc_in = 12'h704; cy(1);
    chk("R7 taken next", int'(irq_ack), 1);
    irq_req = 0; iret_stb = 1; cy(1);
    chk("R7 pop", int'(pc_out), 'h704);
    ret_stb = 1; cy(1);
    chk("R7 pop", int'(pc_out), 'h700);

    // R8: bank overlay
    phase = "R8";
    for (int a = 0; a < 16; a++) begin rf_we = 1; rf_waddr = 4'(a); rf_wdata = 4'(a); cy(0); end
    bank_cmd = 1; bank_val = 1; cy(1);
    chk("R8 bank on", int'(bank_act), 1);
    for (int a = 0; a < 8; a++) begin rf_we = 1; rf_waddr = 4'(a); rf_wdata = 4'(15 - a); cy(0); end
    for (int a = 0; a < 16; a++) begin
      rf_raddr = 4'(a); cy(0);
      chk("R8 overlay read", int'(rf_rdata), (a < 8) ? 15 - a : a);
    end
    bank_cmd = 1; bank_val = 0; cy(1);
    for (int a = 0; a < 8; a++) begin
      rf_raddr = 4'(a); cy(0);
      chk("R8 original kept", int'(rf_rdata), a);
    end

    // R9 / R10: halt, ignored strobes, resume
    phase = "R9";
    call_stb = 1; pc_in = 12'h888; cy(1);
    stop_req = 1; cy(1);
    chk("R9 halted", int'(stop_ack), 1);
    call_stb = 1; pc_in = 12'h900; cy(1);
    ret_stb = 1; cy(1);
    chk("R9 ret ignored", int'(pc_load), 0);
    bank_cmd = 1; bank_val = 1; cy(1);
    chk("R9 bank ignored", int'(bank_act), 0);
    cy(0); cy(1);
    chk("R9 still halted", int'(stop_ack), 1);
    phase = "R10";
    stop_req = 0; cy(1);
    chk("R10 resumed", int'(stop_ack), 0);
    ret_stb = 1; cy(1);
    chk("R10 stack untouched while halted", int'(pc_out), 'h888);

    // R11: single step
    phase = "R11";
    step_mode = 1; stop_req = 1; cy(1);
    stop_req = 0; cy(1);
    chk("R11 step released", int'(stop_ack), 0);
    stop_req = 1; cy(0); cy(0);
    chk("R11 running mid-step", int'(stop_ack), 0);
    cy(1);
    chk("R11 halted after one", int'(stop_ack), 1);
    stop_req = 0; cy(1);
    chk("R11 second step", int'(stop_ack), 0);
    cy(1);
    chk("R11 rehalt with stop low", int'(stop_ack), 1);
    step_mode = 0; cy(1);
    chk("R11 plain resume", int'(stop_ack), 0);

    // R12: wake by interrupt
    phase = "R12";
    stop_req = 1; cy(1);
    irq_req = 1; pc_in = 12'hC00; stop_req = 0; cy(1);
    chk("R12 ack", int'(irq_ack), 1);
    chk("R12 woken", int'(stop_ack), 0);
    irq_req = 0; iret_stb = 1; cy(1);
    chk("R12 pop", int'(pc_out), 'hC00);

    // R13: interrupt before halt
    phase = "R13";
    irq_req = 1; stop_req = 1; pc_in = 12'hD00; cy(1);
    chk("R13 ack first", int'(irq_ack), 1);
    chk("R13 not halted yet", int'(stop_ack), 0);
    irq_req = 0; cy(1);
    chk("R13 halted next", int'(stop_ack), 1);
    stop_req = 0; cy(1);
    iret_stb = 1; cy(1);
    chk("R13 pop", int'(pc_out), 'hD00);

    // random mix against the model (R2..R13)
    phase = "RND";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      pc_in = 12'($urandom);
      if (r == 0) call_stb = 1;
      else if (r == 1 && mq.size() > 0) ret_stb = 1;
      else if (r == 2 && mq.size() > 0) iret_stb = 1;
      else if (r == 3) irq_on_cmd = 1;
      else if (r == 4) begin bank_cmd = 1; bank_val = 1'($urandom); end
      if ($urandom_range(0, 7) == 0) irq_req = ~irq_req;
      if ($urandom_range(0, 11) == 0) stop_req = ~stop_req;
      if ($urandom_range(0, 40) == 0) step_mode = ~step_mode;
      rf_we = 1'($urandom); rf_waddr = 4'($urandom); rf_wdata = 4'($urandom);
      rf_raddr = 4'($urandom);
      cy(($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule